// File: doc/BRIEF.md
# Dual-Slope Integrating ADC Controller

This block is the digital sequencer of an integrating converter built from an external integrator, a comparator and a three-way analog switch. On a start pulse it routes the unknown input into the integrator for a fixed window of 2^N clocks. It then routes the negative reference in and counts clocks until the comparator reports that the integrator output is back at zero. Since the charge window is fixed, the discharge count is proportional to the input: the input equals the reference times count / 2^N. The count is presented directly as the N-bit result.

The controller has three states. AUTOZERO is the rest state: the switch is open and the integrator is held at zero. Transition GO moves AUTOZERO to CHARGE when a start pulse is seen. CHARGE connects the input and lasts exactly 2^N cycles. Transition FLIP moves CHARGE to RUNDOWN when the phase counter reaches all-ones. RUNDOWN connects the negative reference and counts. Transition ZERO_HIT returns RUNDOWN to AUTOZERO when the comparator reads low. Transition CLIP returns RUNDOWN to AUTOZERO when 2^N discharge clocks pass without a trip. Both return transitions latch the result and pulse done. A start pulse seen outside AUTOZERO has no effect. The conversion time therefore depends on the input level.

Top module: `dual_slope_ctrl`

## Requirements
- R1: After reset, sw_sel_o is 2'b00, done_o is 0, result_o is 0 and ovr_o is 0.
- R2: While no conversion is running, sw_sel_o is 2'b00 (switch open, integrator held at zero).
- R3: The first rising edge with start_i high in AUTOZERO starts a conversion. From the cycle after that edge, sw_sel_o is 2'b01 (input connected) for exactly 2^N cycles.
- R4: After the charge window, sw_sel_o is 2'b10 (negative reference connected) until the conversion ends. It returns to 2'b00 in the same cycle that done_o rises.
- R5: The result is k, the number of rundown edges at which cmp_i (high while the integrator is above zero) was sampled high before the first edge at which it was sampled low. In that case ovr_o is 0 and done_o rises 2^N + k + 1 cycles after the start edge.
- R6: If cmp_i is still high at the 2^N-th rundown edge, result_o is all-ones and ovr_o is 1. done_o then rises 2^(N+1) cycles after the start edge.
- R7: done_o is high for exactly one cycle, and result_o and ovr_o take their new values in that cycle. Both outputs hold their values until the next done_o pulse.
- R8: start_i is ignored while a conversion is running. It neither restarts nor lengthens that conversion, and it does not queue a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled in AUTOZERO |
| cmp_i | input | 1 | Comparator, high while integrator is above zero |
| sw_sel_o | output | 2 | Switch select: 00 open, 01 input, 10 negative reference |
| result_o | output | N | Latched discharge count |
| done_o | output | 1 | One-cycle end-of-conversion strobe |
| ovr_o | output | 1 | Latched overrange flag |

## Verification
A phase counter that is cleared at the wrong point, or a state that leaves early, changes how long sw_sel_o stays at 01. The bench sees this within one conversion, as a wrong charge length or a wrong done latency. A rundown exit that misreads the comparator shows as a result that differs from the input code by one or more, or as a wrong ovr_o, at the very next done_o. A state machine that reacts to start_i out of AUTOZERO shows as a switch select that leaves 00 after done_o, or as a stretched conversion time.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
    typedef enum logic [1:0] {
        ST_AUTOZERO = 2'b00,
        ST_CHARGE   = 2'b01,
        ST_RUNDOWN  = 2'b10
    } dsadc_state_t;

    typedef enum logic [1:0] {
        SW_OPEN = 2'b00,
        SW_VIN  = 2'b01,
        SW_VREF = 2'b10
    } dsadc_sw_t;
endpackage

// File: rtl/dsadc_phase_cnt.sv
module dsadc_phase_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] cnt_o,
    output logic         full_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (clr_i)  cnt_o <= '0;
        else if (en_i)   cnt_o <= cnt_o + 1'b1;
    end

    assign full_o = &cnt_o;

    // R3: the counter advances by exactly one per enabled cycle
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !clr_i && en_i && !full_o) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
    import dsadc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      cmp_i,
    input  logic      full_i,
    output dsadc_sw_t sw_o,
    output logic      clr_o,
    output logic      en_o,
    output logic      cap_o,
    output logic      clip_o
);
    dsadc_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_AUTOZERO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        sw_o    = SW_OPEN;
        clr_o   = 1'b0;
        en_o    = 1'b0;
        cap_o   = 1'b0;
        clip_o  = 1'b0;
        unique case (state_q)
            ST_AUTOZERO: begin
                if (start_i) begin
                    state_d = ST_CHARGE;
                    clr_o   = 1'b1;
                end
            end
            ST_CHARGE: begin
                sw_o = SW_VIN;
                if (full_i) begin
                    state_d = ST_RUNDOWN;
                    clr_o   = 1'b1;
                end else begin
                    en_o = 1'b1;
                end
            end
            ST_RUNDOWN: begin
                sw_o = SW_VREF;
                if (!cmp_i) begin
                    state_d = ST_AUTOZERO;
                    cap_o   = 1'b1;
                end else if (full_i) begin
                    state_d = ST_AUTOZERO;
                    cap_o   = 1'b1;
                    clip_o  = 1'b1;
                end else begin
                    en_o = 1'b1;
                end
            end
            default: state_d = ST_AUTOZERO;
        endcase
    end

    // R3: the charge window is not cut short
    a_r3_charge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHARGE && !full_i) |=> (state_q == ST_CHARGE));
    // R8: a running conversion never drops straight back to rest from charge
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHARGE) |=> (state_q != ST_AUTOZERO));
    // R4: rundown continues while the comparator is high and the count has room
    a_r4_rundown_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUNDOWN && cmp_i && !full_i) |=> (state_q == ST_RUNDOWN));
endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic         clip_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] result_o,
    output logic         ovr_o,
    output logic         done_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            ovr_o    <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= cap_i;
            if (cap_i) begin
                result_o <= clip_i ? {W{1'b1}} : cnt_i;
                ovr_o    <= clip_i;
            end
        end
    end

    // R6: an overrange result is always saturated
    a_r6_ovr_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> (&result_o));
    // R7: done lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7: outputs are stable between strobes
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_i && $past(rst_n)) |=> ($stable(result_o) && $stable(ovr_o)));
endmodule

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
    import dsadc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         cmp_i,
    output logic [1:0]   sw_sel_o,
    output logic [N-1:0] result_o,
    output logic         done_o,
    output logic         ovr_o
);
    localparam int CNT_W = N;

    dsadc_sw_t        sw;
    logic             clr, en, cap, clip, full;
    logic [CNT_W-1:0] cnt;

    dsadc_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(en),
        .cnt_o(cnt), .full_o(full)
    );

    dsadc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .full_i(full), .sw_o(sw), .clr_o(clr), .en_o(en),
        .cap_o(cap), .clip_o(clip)
    );

    dsadc_result #(.W(CNT_W)) u_res (
        .clk(clk), .rst_n(rst_n), .cap_i(cap), .clip_i(clip), .cnt_i(cnt),
        .result_o(result_o), .ovr_o(ovr_o), .done_o(done_o)
    );

    assign sw_sel_o = sw;

    // R4: the switch is open in the cycle the strobe appears
    a_r4_open_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sw_sel_o == 2'b00));
endmodule

// File: tb/dual_slope_ctrl_tb.sv
module dual_slope_ctrl_tb;
    localparam int N          = 8;
    localparam int CLK_PERIOD = 10;
    localparam int FULL       = 1 << N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         cmp_i;
    logic [1:0]   sw_sel_o;
    logic [N-1:0] result_o;
    logic         done_o;
    logic         ovr_o;

    int checks = 0;
    int errors = 0;
    int acc = 0;
    int vin_code = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_slope_ctrl #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .sw_sel_o(sw_sel_o), .result_o(result_o), .done_o(done_o), .ovr_o(ovr_o)
    );

    // integrator model: one unit of charge per clock per input code step
    always @(posedge clk) begin
        if (!rst_n) acc <= 0;
        else case (sw_sel_o)
            2'b01:   acc <= acc + vin_code;
            2'b10:   acc <= acc - FULL;
            default: acc <= 0;
        endcase
    end
    assign cmp_i = (acc > 0);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_result(input int k);
        return (k >= FULL) ? FULL - 1 : k;
    endfunction
    function automatic int exp_ovr(input int k);
        return (k >= FULL) ? 1 : 0;
    endfunction
    function automatic int exp_latency(input int k);
        return (k >= FULL) ? 2 * FULL : FULL + k + 1;
    endfunction

    task automatic convert(input int k, input bit inject);
        int n = 0;
        int inj;
        int lat = exp_latency(k);
        int sel_bad = 0;
        logic [N-1:0] res_seen;
        logic ovr_seen;
        inj = inject ? 1 + int'($urandom % (lat - 1)) : -1;
        vin_code = k;
        @(negedge clk); start_i = 1'b1;
        @(posedge clk); #1; start_i = 1'b0;
        if (sw_sel_o != 2'b01) sel_bad++;
        forever begin
            @(posedge clk); #1;
            n++;
            start_i = (n == inj);
            if (done_o) break;
            if (n < FULL && sw_sel_o != 2'b01) sel_bad++;
            if (n >= FULL && sw_sel_o != 2'b10) sel_bad++;
            if (n > 4 * FULL) break;
        end
        start_i = 1'b0;
        check(sel_bad == 0, "R3/R4 switch phases", sel_bad, 0);
        check(n == lat, (k >= FULL) ? "R6 latency" : "R5 latency", n, lat);
        check(int'(result_o) == exp_result(k), (k >= FULL) ? "R6 result" : "R5 result",
              int'(result_o), exp_result(k));
        check(int'(ovr_o) == exp_ovr(k), (k >= FULL) ? "R6 ovr" : "R5 ovr",
              int'(ovr_o), exp_ovr(k));
        check(sw_sel_o == 2'b00, "R4 open at done", int'(sw_sel_o), 0);
        res_seen = result_o;
        ovr_seen = ovr_o;
        @(posedge clk); #1;
        check(done_o == 1'b0, "R7 done one cycle", int'(done_o), 0);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
        end
        check(result_o == res_seen && ovr_o == ovr_seen, "R7 result held",
              int'(result_o), int'(res_seen));
        if (inject)
            check(sw_sel_o == 2'b00, "R8 start ignored, no new conversion", int'(sw_sel_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20517));
        repeat (3) @(posedge clk);
        #1;
        check(sw_sel_o == 2'b00, "R1 sel reset", int'(sw_sel_o), 0);
        check(done_o == 1'b0 && ovr_o == 1'b0, "R1 flags reset", int'({done_o, ovr_o}), 0);
        check(result_o == '0, "R1 result reset", int'(result_o), 0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            check(sw_sel_o == 2'b00, "R2 idle open", int'(sw_sel_o), 0);
        end
        // directed corners
        convert(0, 1'b0);
        convert(1, 1'b0);
        convert(FULL - 1, 1'b0);
        convert(FULL, 1'b0);
        convert(FULL + 37, 1'b1);
        convert(FULL / 2, 1'b1);
        // random input levels, some with stray start pulses
        for (int t = 0; t < 30; t++) begin
            int k = int'($urandom % (FULL + 40));
            convert(k, bit'($urandom % 2));
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule